// File: doc/BRIEF.md
# Masked Event Interrupt Aggregator

This block collects 96 single-cycle event pulses into a shared set of sticky pending bits and spreads them across three interrupt lines. Each line has its own bank of mask words; a line is raised while at least one pending event is enabled in its bank. For every line the block also names the lowest-numbered pending, enabled event, so an interrupt handler can find its work in one read of the index pins rather than by scanning registers.

Software sees a flat map of 32-bit words through a plain register port. A write is taken on the clock edge at which `reg_we` is high. Read data follows `reg_addr` combinationally. Pending bits are cleared by writing ones. Mask words are plain read/write storage, so software changes a single enable by read-modify-write. The port has no handshake: every access completes in one cycle and none can be stalled, so no valid/ready pair applies.

Top module: `evt_irq_ctrl`

## Requirements
- R1: The pending bits are readable as three words. Offset 0x00 holds events 0-31, offset 0x04 holds events 32-63 and offset 0x08 holds events 64-95. Event e sits at bit e mod 32 of its word.
- R2: A high bit of `evt_pulse` at a clock edge sets the matching pending bit. The bit stays set on later cycles without further pulses.
- R3: A write to a pending word clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R4: If a pulse and a write-one clear hit the same bit at the same edge, the bit ends up set.
- R5: The mask word for group g (0..2) and word w (0..2) is at offset 0x10 + 0x10*g + 4*w. It stores the full 32-bit value written and reads it back unchanged.
- R6: `irq_line[g]` is high exactly when pending AND group-g mask is nonzero over all 96 events. Bit 0 drives the level-13 line, bit 1 the level-11 line and bit 2 the level-9 line.
- R7: `pick_idx[7*g +: 7]` gives the lowest event number e (0..95, where e = 32*w + bit) that is both pending and enabled in group g.
- R8: `pick_vld[g]` is high exactly when group g has a pending, enabled event. When it is low, that group's index reads 0.
- R9: Reset clears all pending and mask bits. Reads of any other offset return 0, and writes to other offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_pulse | input | 96 | One bit per event, high for one cycle when the event fires |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the accessed word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_line | output | 3 | Interrupt lines, one per mask group |
| pick_vld | output | 3 | Per-group flag: an enabled event is pending |
| pick_idx | output | 21 | Per-group 7-bit index of the lowest enabled pending event |

## Verification
The properties assume that `evt_pulse`, `reg_we`, `reg_addr` and `reg_wdata` hold known values at every sampled edge after reset. They also assume that any offset may be presented, including unaligned or unmapped ones, and that pulses may coincide with clears. The stimulus drives every input on the falling edge and keeps event density low, so individual pending bits survive long enough to be seen. Writes mostly target the twelve mapped words, with a share aimed at unmapped offsets. Same-edge collisions are forced both by directed steps and by the random mix.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int WORD_W       = 32;
  localparam int N_WORDS      = 3;
  localparam int N_GROUPS     = 3;
  localparam int ADDR_W       = 8;
  localparam int STAT_BASE    = 'h00;
  localparam int MASK_BASE    = 'h10;
  localparam int GROUP_STRIDE = 'h10;
  localparam int WORD_STRIDE  = 4;
  localparam int EVT_N        = WORD_W * N_WORDS;
  localparam int IDX_W        = $clog2(EVT_N);
endpackage

// File: rtl/evt_status_bank.sv
module evt_status_bank #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 3,
  parameter int ADDR_W  = 8,
  parameter int BASE    = 0,
  parameter int STRIDE  = 4,
  localparam int EVT_N  = WORD_W * N_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_N-1:0]  evt,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic [EVT_N-1:0]  pending
);
  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(BASE + STRIDE * w);
    logic              hit;
    logic [WORD_W-1:0] clr;
    logic [WORD_W-1:0] cur;
    assign hit = wr_en && (wr_addr == OFS);
    assign clr = hit ? wr_data : '0;
    assign cur = pending[w*WORD_W +: WORD_W];
    // set dominates clear on the same edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pending[w*WORD_W +: WORD_W] <= '0;
      else        pending[w*WORD_W +: WORD_W] <= (cur & ~clr) | evt[w*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/evt_mask_bank.sv
module evt_mask_bank #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 3,
  parameter int ADDR_W  = 8,
  parameter int BASE    = 'h10,
  parameter int STRIDE  = 4,
  localparam int EVT_N  = WORD_W * N_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic [EVT_N-1:0]  enable
);
  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(BASE + STRIDE * w);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            enable[w*WORD_W +: WORD_W] <= '0;
      else if (wr_en && (wr_addr == OFS))    enable[w*WORD_W +: WORD_W] <= wr_data;
    end
  end
endmodule

// File: rtl/evt_lowest_pick.sv
module evt_lowest_pick #(
  parameter int N     = 96,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
  assign found = |vec;
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int P_WORD_W   = WORD_W,
  parameter int P_N_WORDS  = N_WORDS,
  parameter int P_N_GROUPS = N_GROUPS,
  parameter int P_ADDR_W   = ADDR_W,
  localparam int L_EVT_N   = P_WORD_W * P_N_WORDS,
  localparam int L_IDX_W   = $clog2(L_EVT_N)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [L_EVT_N-1:0]            evt_pulse,
  input  logic                          reg_we,
  input  logic [P_ADDR_W-1:0]           reg_addr,
  input  logic [P_WORD_W-1:0]           reg_wdata,
  output logic [P_WORD_W-1:0]           reg_rdata,
  output logic [P_N_GROUPS-1:0]         irq_line,
  output logic [P_N_GROUPS-1:0]         pick_vld,
  output logic [P_N_GROUPS*L_IDX_W-1:0] pick_idx
);
  logic [L_EVT_N-1:0] status_vec;
  logic [L_EVT_N-1:0] mask_vec [P_N_GROUPS];

  evt_status_bank #(
    .WORD_W(P_WORD_W), .N_WORDS(P_N_WORDS), .ADDR_W(P_ADDR_W),
    .BASE(STAT_BASE), .STRIDE(WORD_STRIDE)
  ) u_status (
    .clk(clk), .rst_n(rst_n), .evt(evt_pulse),
    .wr_en(reg_we), .wr_addr(reg_addr), .wr_data(reg_wdata),
    .pending(status_vec)
  );

  for (genvar g = 0; g < P_N_GROUPS; g++) begin : g_grp
    logic [L_EVT_N-1:0] live;
    logic               found;

    evt_mask_bank #(
      .WORD_W(P_WORD_W), .N_WORDS(P_N_WORDS), .ADDR_W(P_ADDR_W),
      .BASE(MASK_BASE + GROUP_STRIDE * g), .STRIDE(WORD_STRIDE)
    ) u_mask (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_we), .wr_addr(reg_addr), .wr_data(reg_wdata),
      .enable(mask_vec[g])
    );

    assign live = status_vec & mask_vec[g];
    assign irq_line[g] = |live;

    evt_lowest_pick #(.N(L_EVT_N), .IDX_W(L_IDX_W)) u_pick (
      .vec(live), .found(found), .idx(pick_idx[g*L_IDX_W +: L_IDX_W])
    );
    assign pick_vld[g] = found;
  end

  always_comb begin
    reg_rdata = '0;
    for (int w = 0; w < P_N_WORDS; w++) begin
      if (reg_addr == P_ADDR_W'(STAT_BASE + WORD_STRIDE * w))
        reg_rdata = status_vec[w*P_WORD_W +: P_WORD_W];
    end
    for (int g = 0; g < P_N_GROUPS; g++) begin
      for (int w = 0; w < P_N_WORDS; w++) begin
        if (reg_addr == P_ADDR_W'(MASK_BASE + GROUP_STRIDE * g + WORD_STRIDE * w))
          reg_rdata = mask_vec[g][w*P_WORD_W +: P_WORD_W];
      end
    end
  end
endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk #(
  parameter int EVT_N = 96,
  parameter int NG    = 3,
  parameter int IW    = 7,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [EVT_N-1:0] evt_pulse,
  input logic             reg_we,
  input logic [AW-1:0]    reg_addr,
  input logic [DW-1:0]    reg_wdata,
  input logic [EVT_N-1:0] status_vec,
  input logic [NG-1:0]    irq_line,
  input logic [NG-1:0]    pick_vld,
  input logic [NG*IW-1:0] pick_idx
);
  AST_EVT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_pulse) |=> ((status_vec & $past(evt_pulse)) == $past(evt_pulse))); // R2

  AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_wdata == '0 && evt_pulse == '0) |=> $stable(status_vec)); // R3

  AST_ONE_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == '0 && evt_pulse == '0)
      |=> ((status_vec[DW-1:0] & $past(reg_wdata)) == '0)); // R3

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == '0 && |(evt_pulse[DW-1:0] & reg_wdata))
      |=> ((status_vec[DW-1:0] & $past(evt_pulse[DW-1:0])) == $past(evt_pulse[DW-1:0]))); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (status_vec == '0) |-> (irq_line == '0)); // R6

  AST_VLD_TRACKS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    pick_vld == irq_line); // R8

  for (genvar g = 0; g < NG; g++) begin : g_chk
    AST_PICK_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      pick_vld[g] |-> (int'(pick_idx[g*IW +: IW]) < EVT_N
                       && status_vec[pick_idx[g*IW +: IW]])); // R7
    AST_IDX_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !pick_vld[g] |-> (pick_idx[g*IW +: IW] == '0)); // R8
  end
endmodule

bind evt_irq_ctrl evt_irq_chk #(
  .EVT_N(L_EVT_N), .NG(P_N_GROUPS), .IW(L_IDX_W), .AW(P_ADDR_W), .DW(P_WORD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .status_vec(status_vec),
  .irq_line(irq_line), .pick_vld(pick_vld), .pick_idx(pick_idx)
);

// File: tb/evt_irq_ctrl_tb_top.sv
module evt_irq_ctrl_tb_top;
  localparam int EW = 96;
  localparam int NG = 3;
  localparam int IW = 7;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [EW-1:0] evt_pulse;
  logic          reg_we;
  logic [7:0]    reg_addr;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic [NG-1:0] irq_line, pick_vld;
  logic [NG*IW-1:0] pick_idx;

  always #5 clk = ~clk;

  evt_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_line(irq_line), .pick_vld(pick_vld), .pick_idx(pick_idx)
  );

  logic [EW-1:0] m_stat;
  logic [EW-1:0] m_mask [NG];
  int total = 0;
  int bad = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(logic [7:0] a);
    logic [31:0] r = '0;
    if (a == 8'h00) r = m_stat[31:0];
    if (a == 8'h04) r = m_stat[63:32];
    if (a == 8'h08) r = m_stat[95:64];
    for (int g = 0; g < NG; g++)
      for (int w = 0; w < 3; w++)
        if (a == 8'(16 + 16 * g + 4 * w)) r = m_mask[g][w*32 +: 32];
    return r;
  endfunction

  function automatic logic [6:0] m_low(logic [EW-1:0] v);
    logic [6:0] r = '0;
    for (int i = EW - 1; i >= 0; i--) if (v[i]) r = 7'(i);
    return r;
  endfunction

  task automatic check_outs(string req);
    for (int g = 0; g < NG; g++) begin
      logic [EW-1:0] live;
      live = m_stat & m_mask[g];
      chk({req, " line"}, 32'(irq_line[g]), 32'(|live));
      chk({req, " vld"},  32'(pick_vld[g]), 32'(|live));
      chk({req, " idx"},  32'(pick_idx[g*IW +: IW]), 32'(m_low(live)));
    end
  endtask

  task automatic rd_chk(logic [7:0] a, string req);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, m_read(a));
  endtask

  task automatic step(logic [EW-1:0] ev, logic we, logic [7:0] a, logic [31:0] d, string req);
    @(negedge clk);
    evt_pulse = ev; reg_we = we; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    if (we) begin
      for (int w = 0; w < 3; w++)
        if (a == 8'(4 * w)) m_stat[w*32 +: 32] = m_stat[w*32 +: 32] & ~d;
      for (int g = 0; g < NG; g++)
        for (int w = 0; w < 3; w++)
          if (a == 8'(16 + 16 * g + 4 * w)) m_mask[g][w*32 +: 32] = d;
    end
    m_stat = m_stat | ev;
    #1;
    evt_pulse = '0; reg_we = 1'b0;
    check_outs(req);
  endtask

  function automatic logic [7:0] pick_addr();
    logic [7:0] mapped [12] = '{8'h00, 8'h04, 8'h08, 8'h10, 8'h14, 8'h18,
                                8'h20, 8'h24, 8'h28, 8'h30, 8'h34, 8'h38};
    int r = int'($urandom_range(0, 15));
    if (r < 12) return mapped[r];
    return 8'($urandom_range(0, 255));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; evt_pulse = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    m_stat = '0;
    for (int g = 0; g < NG; g++) m_mask[g] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R9: reset state
    check_outs("R9 reset");
    for (int a = 0; a < 64; a += 4) rd_chk(8'(a), "R9 reset read");

    // R5: mask storage
    step('0, 1'b1, 8'h20, 32'h0000_0020, "R5");
    step('0, 1'b1, 8'h28, 32'h0000_0040, "R5");
    rd_chk(8'h20, "R5 readback");
    chk("R5 literal", reg_rdata, 32'h0000_0020);
    // R2 / R7: events 5 and 70, group 1 sees the lower one
    step((96'd1 << 5) | (96'd1 << 70), 1'b0, 8'h00, 32'h0, "R2");
    chk("R7 lowest", 32'(pick_idx[IW +: IW]), 32'd5);
    chk("R6 line1", 32'(irq_line), 32'b010);
    chk("R8 idle idx g0", 32'(pick_idx[0 +: IW]), 32'd0);
    step('0, 1'b0, 8'h00, 32'h0, "R2 sticky");
    rd_chk(8'h08, "R1 word2");
    chk("R1 word2 literal", reg_rdata, 32'h0000_0040);
    // R6: masking bit 5 leaves event 70 as the pick
    step('0, 1'b1, 8'h20, 32'h0, "R6");
    chk("R7 next", 32'(pick_idx[IW +: IW]), 32'd70);
    // R3: zero write leaves status
    step('0, 1'b1, 8'h00, 32'h0, "R3 zero");
    rd_chk(8'h00, "R3 zero read");
    chk("R3 literal", reg_rdata, 32'h0000_0020);
    // R4: collision
    step(96'd1 << 5, 1'b1, 8'h00, 32'h0000_0020, "R4");
    rd_chk(8'h00, "R4 read");
    chk("R4 literal", reg_rdata, 32'h0000_0020);
    // R3: clear
    step('0, 1'b1, 8'h00, 32'h0000_0020, "R3 clear");
    rd_chk(8'h00, "R3 clear read");
    chk("R3 cleared literal", reg_rdata, 32'h0);
    // R9: unmapped offsets
    step('0, 1'b1, 8'h0C, 32'hFFFF_FFFF, "R9 unmapped wr");
    step('0, 1'b1, 8'h40, 32'hFFFF_FFFF, "R9 unmapped wr");
    step('0, 1'b1, 8'h21, 32'hFFFF_FFFF, "R9 unaligned wr");
    rd_chk(8'h0C, "R9 unmapped rd");
    rd_chk(8'h40, "R9 unmapped rd");
    for (int a = 0; a < 64; a += 4) rd_chk(8'(a), "R9 unchanged");

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [EW-1:0] ev;
      logic          we;
      logic [31:0]   d;
      for (int w = 0; w < 3; w++)
        ev[w*32 +: 32] = $urandom & $urandom & $urandom & $urandom;
      if ($urandom_range(0, 3) != 0) ev = '0;
      we = ($urandom_range(0, 1) == 1);
      d  = ($urandom_range(0, 1) == 1) ? $urandom : ($urandom | $urandom);
      step(ev, we, pick_addr(), d, "R6 R7 random");
      rd_chk(pick_addr(), "R1 R5 random read");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule